// File: doc/BRIEF.md
# Compare-Output Interval Timer

This block is a 16-bit up-counter that advances once for every cycle in which its tick enable is high. The tick enable stands in for the output of a clock prescaler that sits outside the block. There are two ways to run it. In the free-running mode the count wraps from all ones back to zero and raises a sticky overflow flag. In the two interval modes the count returns to zero after it reaches a top value. That top value comes either from the compare register or from a separate period register, and the mode code picks which one.

One compare channel watches the count. When the count equals the compare value on a tick, the channel raises a sticky match flag and performs a pin action on the waveform output: hold, toggle, drive low or drive high. The action field can be rewritten at any time, but the pin only moves at a match. A force strobe performs the selected action at once. It does not touch the match flag or the count.

Software loads every register through one write port. The same port sets the count directly, and a match that would fall in the cycle of such a load is dropped.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous reset the count is 0 and both flags and the waveform pin are 0. The compare register and the period register both reset to 0xFFFF, and the mode code and action field reset to 0.
- R2: The count rises by one on each clock edge that follows a cycle with `tick_en` high, and it holds when `tick_en` is low. Mode code 0, and any code other than 4 or 12, never clears the count on a match.
- R3: A tick taken while the count is 0xFFFF makes the count 0, and the overflow flag reads 1 from that same edge. No later tick clears it.
- R4: With mode code 4, a tick taken while the count equals the compare register loads 0 instead of count+1.
- R5: With mode code 12, a tick taken while the count equals the period register loads 0. A match with the compare register then sets the flag and acts on the pin without clearing the count.
- R6: A tick taken while the count equals the compare register sets the match flag at the following edge.
- R7: At a match the pin follows the 2-bit action field in control bits [5:4]: 00 holds, 01 toggles, 10 drives 0, 11 drives 1. The mode code sits in control bits [3:0].
- R8: A write to the action field leaves the pin unchanged until the next match or force strobe.
- R9: `force_stb` performs the current action on the pin at the next edge. It leaves the match flag and the count unchanged.
- R10: `ovf_clr` and `cmf_clr` each clear their flag at the next edge. When a set and a clear of the same flag arrive in one cycle, the flag ends up at 1.
- R11: A count load takes effect at the next edge in any mode and overrides a tick. A compare match in the load cycle is suppressed.
- R12: `wr_sel` chooses the target of a write: 0 = count, 1 = compare register, 2 = period register, 3 = control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count enable, one pulse per timer tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 16 | Write data |
| force_stb | input | 1 | Immediate pin action strobe |
| ovf_clr | input | 1 | Clear the overflow flag |
| cmf_clr | input | 1 | Clear the match flag |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmf_flag | output | 1 | Sticky compare match flag |
| wave_out | output | 1 | Waveform pin |

## Verification
Every result of this block lands exactly one edge after the cycle that causes it: the next count, a flag set or clear, a pin action, and a register load. The decision for a cycle is made from the register values held during that cycle. So a compare value that is written takes part in matching only from the following cycle onward. The driver applies each cycle's inputs at the falling edge and queues the outputs due after the coming rising edge. The monitor pops that item one nanosecond after the rising edge and compares it, so no check ever looks at a result one cycle early or late.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

   // write target select
   typedef enum logic [1:0] {
      SEL_COUNT = 2'd0,
      SEL_CMP   = 2'd1,
      SEL_TOP   = 2'd2,
      SEL_CTRL  = 2'd3
   } wr_target_e;

   // pin action at a match or force
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_LOW    = 2'b10,
      ACT_HIGH   = 2'b11
   } pin_act_e;

   localparam int MODE_W = 4;
   localparam logic [MODE_W-1:0] MODE_FREE    = 4'd0;
   localparam logic [MODE_W-1:0] MODE_CLR_CMP = 4'd4;
   localparam logic [MODE_W-1:0] MODE_CLR_TOP = 4'd12;

   // control word layout
   localparam int CTRL_MODE_LSB = 0;
   localparam int CTRL_ACT_LSB  = 4;

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
   import cmp_timer_pkg::*;
#(
   parameter int  W           = 16,
   parameter bit  HAS_TOP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [W-1:0]      wr_data,
   output logic [W-1:0]      cmp_q,
   output logic [W-1:0]      alt_q,
   output logic [MODE_W-1:0] mode_q,
   output logic [1:0]        act_q
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   logic wr_cmp, wr_top, wr_ctrl;

   always_comb begin
      wr_cmp  = wr_en && (wr_sel == SEL_CMP);
      wr_top  = wr_en && (wr_sel == SEL_TOP);
      wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
   end

   // compare register
   always_ff @(posedge clk) begin
      if (rst)         cmp_q <= ALL_ONES;
      else if (wr_cmp) cmp_q <= wr_data;
   end

   // period register, optional
   generate
      if (HAS_TOP_REG) begin : g_top_reg
         always_ff @(posedge clk) begin
            if (rst)         alt_q <= ALL_ONES;
            else if (wr_top) alt_q <= wr_data;
         end
      end else begin : g_top_fixed
         logic unused_top;
         always_comb unused_top = wr_top;
         assign alt_q = ALL_ONES;
      end
   endgenerate

   // control word: mode code and pin action field
   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_FREE;
         act_q  <= ACT_HOLD;
      end else if (wr_ctrl) begin
         mode_q <= wr_data[CTRL_MODE_LSB +: MODE_W];
         act_q  <= wr_data[CTRL_ACT_LSB +: 2];
      end
   end

endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick_en,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         clr_at_top,
   input  logic [W-1:0] top_val,
   input  logic         ovf_clr,
   output logic [W-1:0] count,
   output logic         ovf_flag
);
   localparam logic [W-1:0] MAX_CNT = {W{1'b1}};
   localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

   logic         at_top;
   logic         wrap;
   logic [W-1:0] count_d;

   always_comb begin
      at_top = clr_at_top && (count == top_val);
      wrap   = tick_en && !load_en && (count == MAX_CNT);
      if (load_en)      count_d = load_val;
      else if (!tick_en) count_d = count;
      else if (at_top)  count_d = '0;
      else              count_d = count + ONE;
   end

   always_ff @(posedge clk) begin
      if (rst) count <= '0;
      else     count <= count_d;
   end

   // sticky overflow; a set beats a clear
   always_ff @(posedge clk) begin
      if (rst)          ovf_flag <= 1'b0;
      else if (wrap)    ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
   end

endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match
   import cmp_timer_pkg::*;
#(
   parameter int W         = 16,
   parameter bit WAVE_INIT = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick_en,
   input  logic         load_en,
   input  logic [W-1:0] count,
   input  logic [W-1:0] cmp_val,
   input  logic [1:0]   act,
   input  logic         force_stb,
   input  logic         cmf_clr,
   output logic         cmf_flag,
   output logic         wave_out
);
   logic hit;
   logic apply;
   logic wave_d;

   always_comb begin
      hit   = tick_en && !load_en && (count == cmp_val);
      apply = hit || force_stb;
      wave_d = wave_out;
      if (apply) begin
         case (pin_act_e'(act))
            ACT_TOGGLE: wave_d = !wave_out;
            ACT_LOW:    wave_d = 1'b0;
            ACT_HIGH:   wave_d = 1'b1;
            default:    wave_d = wave_out;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)          cmf_flag <= 1'b0;
      else if (hit)     cmf_flag <= 1'b1;
      else if (cmf_clr) cmf_flag <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) wave_out <= WAVE_INIT;
      else     wave_out <= wave_d;
   end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import cmp_timer_pkg::*;
#(
   parameter int W           = 16,
   parameter bit HAS_TOP_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick_en,
   input  logic         wr_en,
   input  logic [1:0]   wr_sel,
   input  logic [15:0]  wr_data,
   input  logic         force_stb,
   input  logic         ovf_clr,
   input  logic         cmf_clr,
   output logic [15:0]  count,
   output logic         ovf_flag,
   output logic         cmf_flag,
   output logic         wave_out
);
   localparam int CTRL_BITS = CTRL_ACT_LSB + 2;

   initial begin
      assert (W == 16) else $error("cmp_timer: port width fixed at 16");
      assert (W >= CTRL_BITS) else $error("cmp_timer: width too small for control word");
   end

   logic [W-1:0]      cmp_q;
   logic [W-1:0]      alt_q;
   logic [MODE_W-1:0] mode_q;
   logic [1:0]        act_q;
   logic              load_en;
   logic              clr_at_top;
   logic [W-1:0]      top_val;

   always_comb begin
      load_en    = wr_en && (wr_sel == SEL_COUNT);
      clr_at_top = (mode_q == MODE_CLR_CMP) || (mode_q == MODE_CLR_TOP);
      top_val    = (mode_q == MODE_CLR_TOP) ? alt_q : cmp_q;
   end

   cmp_timer_regs #(.W(W), .HAS_TOP_REG(HAS_TOP_REG)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .cmp_q   (cmp_q),
      .alt_q   (alt_q),
      .mode_q  (mode_q),
      .act_q   (act_q)
   );

   cmp_timer_counter #(.W(W)) u_counter (
      .clk        (clk),
      .rst        (rst),
      .tick_en    (tick_en),
      .load_en    (load_en),
      .load_val   (wr_data),
      .clr_at_top (clr_at_top),
      .top_val    (top_val),
      .ovf_clr    (ovf_clr),
      .count      (count),
      .ovf_flag   (ovf_flag)
   );

   cmp_timer_match #(.W(W), .WAVE_INIT(1'b0)) u_match (
      .clk       (clk),
      .rst       (rst),
      .tick_en   (tick_en),
      .load_en   (load_en),
      .count     (count),
      .cmp_val   (cmp_q),
      .act       (act_q),
      .force_stb (force_stb),
      .cmf_clr   (cmf_clr),
      .cmf_flag  (cmf_flag),
      .wave_out  (wave_out)
   );

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
   import cmp_timer_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic        tick_en,
   input logic        wr_en,
   input logic [1:0]  wr_sel,
   input logic [15:0] wr_data,
   input logic        force_stb,
   input logic        cmf_clr,
   input logic [15:0] count,
   input logic        ovf_flag,
   input logic        cmf_flag,
   input logic        wave_out,
   input logic [15:0] cmp_q,
   input logic [15:0] alt_q,
   input logic [3:0]  mode_q,
   input logic [1:0]  act_q
);
   logic ld;
   logic hit;
   always_comb begin
      ld  = wr_en && (wr_sel == SEL_COUNT);
      hit = tick_en && !ld && (count == cmp_q);
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!tick_en && !ld) |=> $stable(count));

   assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (tick_en && !ld && count == 16'hFFFF) |=> (ovf_flag && count == 16'h0000));

   assert_ctc_cmp_R4: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_CLR_CMP && hit) |=> (count == 16'h0000));

   assert_ctc_top_R5: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_CLR_TOP && tick_en && !ld && count == alt_q) |=> (count == 16'h0000));

   assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
      hit |=> cmf_flag);

   assert_act_high_R7: assert property (@(posedge clk) disable iff (rst)
      ((hit || force_stb) && act_q == ACT_HIGH) |=> wave_out);

   assert_pin_still_R8: assert property (@(posedge clk) disable iff (rst)
      (!hit && !force_stb) |=> $stable(wave_out));

   assert_force_noflag_R9: assert property (@(posedge clk) disable iff (rst)
      (force_stb && !hit && !cmf_flag) |=> !cmf_flag);

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      (hit && cmf_clr) |=> cmf_flag);

   assert_load_R11: assert property (@(posedge clk) disable iff (rst)
      ld |=> (count == $past(wr_data)));

endmodule

bind cmp_timer cmp_timer_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .tick_en   (tick_en),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .force_stb (force_stb),
   .cmf_clr   (cmf_clr),
   .count     (count),
   .ovf_flag  (ovf_flag),
   .cmf_flag  (cmf_flag),
   .wave_out  (wave_out),
   .cmp_q     (cmp_q),
   .alt_q     (alt_q),
   .mode_q    (mode_q),
   .act_q     (act_q)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = 16'h0;
   logic        force_stb = 1'b0;
   logic        ovf_clr = 1'b0;
   logic        cmf_clr = 1'b0;
   logic [15:0] count;
   logic        ovf_flag, cmf_flag, wave_out;

   always #2 clk = ~clk;   // 250 MHz

   cmp_timer u_cmp_timer (
      .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .force_stb(force_stb), .ovf_clr(ovf_clr),
      .cmf_clr(cmf_clr), .count(count), .ovf_flag(ovf_flag),
      .cmf_flag(cmf_flag), .wave_out(wave_out)
   );

   typedef struct {
      logic [15:0] cnt;
      logic        ovf;
      logic        cmf;
      logic        wave;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_vec  = 0;
   int   n_fail = 0;
   bit   done   = 0;

   // reference state, built from the requirements
   logic [15:0] m_cnt, m_cmp, m_top;
   logic [3:0]  m_mode;
   logic [1:0]  m_act;
   logic        m_ovf, m_cmf, m_wave;

   task automatic step(input bit r, input bit tk, input bit we, input logic [1:0] sel,
                       input logic [15:0] d, input bit frc, input bit oc, input bit cc,
                       input string tag);
      bit   ld, hit, ctc, wrapv;
      logic [15:0] top;
      exp_t e;
      @(negedge clk);
      rst = r; tick_en = tk; wr_en = we; wr_sel = sel; wr_data = d;
      force_stb = frc; ovf_clr = oc; cmf_clr = cc;
      if (r) begin
         m_cnt = 0; m_cmp = 16'hFFFF; m_top = 16'hFFFF; m_mode = 0; m_act = 0;
         m_ovf = 0; m_cmf = 0; m_wave = 0;
      end else begin
         ld    = we && sel == 2'd0;
         hit   = tk && !ld && m_cnt == m_cmp;
         ctc   = m_mode == 4'd4 || m_mode == 4'd12;
         top   = (m_mode == 4'd12) ? m_top : m_cmp;
         wrapv = tk && !ld && m_cnt == 16'hFFFF;
         if (hit || frc)
            case (m_act)
               2'b01: m_wave = !m_wave;
               2'b10: m_wave = 1'b0;
               2'b11: m_wave = 1'b1;
               default: ;
            endcase
         if (hit) m_cmf = 1; else if (cc) m_cmf = 0;
         if (wrapv) m_ovf = 1; else if (oc) m_ovf = 0;
         if (ld) m_cnt = d;
         else if (tk) m_cnt = (ctc && m_cnt == top) ? 16'h0 : m_cnt + 16'h1;
         if (we && sel == 2'd1) m_cmp = d;
         if (we && sel == 2'd2) m_top = d;
         if (we && sel == 2'd3) begin m_mode = d[3:0]; m_act = d[5:4]; end
      end
      e.cnt = m_cnt; e.ovf = m_ovf; e.cmf = m_cmf; e.wave = m_wave; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input bit tk, input string tag);
      step(0, tk, 0, 2'd0, 16'h0, 0, 0, 0, tag);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d, input string tag);
      step(0, 0, 1, sel, d, 0, 0, 0, tag);
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_vec++;
         if (count !== e.cnt || ovf_flag !== e.ovf || cmf_flag !== e.cmf || wave_out !== e.wave) begin
            n_fail++;
            $display("FAIL %s: got cnt=%h ovf=%b cmf=%b wave=%b, expected cnt=%h ovf=%b cmf=%b wave=%b",
                     e.tag, count, ovf_flag, cmf_flag, wave_out, e.cnt, e.ovf, e.cmf, e.wave);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      step(1, 0, 0, 2'd0, 16'h0, 0, 0, 0, "R1");
      step(1, 1, 0, 2'd0, 16'h0, 0, 0, 0, "R1");
      // R2 counting follows tick enable
      idle(1, "R2"); idle(0, "R2"); idle(1, "R2"); idle(1, "R2"); idle(0, "R2");
      // R11/R12 count load, R3 wrap and sticky overflow
      wr(2'd0, 16'hFFFD, "R11");
      idle(1, "R3"); idle(1, "R3"); idle(1, "R3"); idle(1, "R3"); idle(0, "R3");
      // R10 overflow clear
      step(0, 0, 0, 2'd0, 16'h0, 0, 1, 0, "R10");
      // R10 set wins over clear on overflow
      wr(2'd0, 16'hFFFF, "R11");
      step(0, 1, 0, 2'd0, 16'h0, 0, 1, 0, "R10");
      step(0, 0, 0, 2'd0, 16'h0, 0, 1, 0, "R10");
      // R12 compare register, R4 clear at compare, R7 toggle, R6 flag
      wr(2'd1, 16'd5, "R12");
      wr(2'd3, 16'h0014, "R12");
      wr(2'd0, 16'd0, "R11");
      for (int i = 0; i < 8; i++) idle(1, "R4");
      // R6 flag stays, then clear; R10 set wins
      step(0, 0, 0, 2'd0, 16'h0, 0, 0, 1, "R10");
      for (int i = 0; i < 3; i++) idle(1, "R6");
      step(0, 1, 0, 2'd0, 16'h0, 0, 0, 1, "R10");
      // R8 action change waits for match; then drive high, low, hold
      wr(2'd3, 16'h0034, "R8");
      idle(0, "R8"); idle(1, "R8"); idle(1, "R8");
      for (int i = 0; i < 6; i++) idle(1, "R7");
      wr(2'd3, 16'h0024, "R8");
      for (int i = 0; i < 6; i++) idle(1, "R7");
      wr(2'd3, 16'h0004, "R7");
      for (int i = 0; i < 6; i++) idle(1, "R7");
      // R9 force: toggle without flag or count change
      wr(2'd3, 16'h0014, "R12");
      step(0, 0, 0, 2'd0, 16'h0, 0, 0, 1, "R9");
      step(0, 0, 0, 2'd0, 16'h0, 1, 0, 0, "R9");
      step(0, 0, 0, 2'd0, 16'h0, 1, 0, 0, "R9");
      wr(2'd3, 16'h0034, "R9");
      step(0, 0, 0, 2'd0, 16'h0, 1, 0, 0, "R9");
      // R5 period register top with compare inside the period
      wr(2'd2, 16'd9, "R12");
      wr(2'd1, 16'd3, "R12");
      wr(2'd3, 16'h001C, "R5");
      wr(2'd0, 16'd0, "R11");
      step(0, 0, 0, 2'd0, 16'h0, 0, 0, 1, "R5");
      for (int i = 0; i < 13; i++) idle(1, "R5");
      // R11 load while at compare suppresses the match
      step(0, 0, 0, 2'd0, 16'h0, 0, 0, 1, "R11");
      wr(2'd0, 16'd3, "R11");
      step(0, 1, 1, 2'd0, 16'd3, 0, 0, 0, "R11");
      idle(0, "R11");
      // R2 unknown mode code acts as free running
      wr(2'd3, 16'h0007, "R2");
      wr(2'd1, 16'd4, "R2");
      for (int i = 0; i < 4; i++) idle(1, "R2");
      repeat (3) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule